// File: doc/BRIEF.md
# Two-Port Memory Built from Single-Port Arrays

This block gives a design one read/write port (port A) and one read-only port (port B) over a shared storage space. It builds that storage only from single-port synchronous RAM arrays. The `MODE` parameter picks one of two ways to do it.

In interleaved mode, one array serves both ports. It is clocked at twice the port rate. Each port cycle is two fast clocks long. The first (even) slot goes to port A and the second (odd) slot goes to port B. The block drives a slot indicator so that the surrounding logic can line up its port-rate transfers with the even slot. Port inputs are held for the whole port cycle. Because the write lands in the even slot and the read in the odd slot, a port B read of an address that port A writes in the same port cycle returns the new value.

In replicated mode, two arrays hold identical contents and run at the port rate. Every port A write goes to both arrays in the same cycle. Port A reads from the first array and port B reads from the second. When a port A write takes the second array, a port B read requested in that cycle cannot be served. A valid flag then stays low and the port B data holds its previous value. After a reset, the memory contents are undefined until they are written.

Top module: `sp_dualport_emu`

## Requirements
- R1: While reset is high, and in the cycle after it, `a_rdata` and `b_rdata` are zero, and `b_valid` and `slot_odd` are low.
- R2: In either mode, a port A read of an address returns the data last written there by port A.
- R3: In interleaved mode, `slot_odd` alternates on every clock after reset, starting low. Port A is served in the even slot (`slot_odd` low before the edge) and port B in the odd slot. Concurrent reads of two different addresses each return their own data.
- R4: In interleaved mode, a port B read of the address that port A writes in the same port cycle returns the newly written data.
- R5: In interleaved mode, `a_rdata` is valid after the port cycle's second clock. `b_rdata` is valid one clock later and holds for a full port cycle (two clocks).
- R6: In replicated mode, a port A write is visible to later port B reads, so both copies stay identical.
- R7: In replicated mode, a port B read requested in the same cycle as a port A write is blocked. In the next cycle `b_valid` is 0 and `b_rdata` is unchanged.
- R8: In replicated mode, both ports have one cycle of read latency. An unblocked port B read gives `b_valid` = 1 in the next cycle, and `b_valid` is 0 after a cycle with no port B read.
- R9: With `a_en` low, a high `a_we` writes nothing, so the stored word remains readable unchanged.
- R10: In interleaved mode, `b_valid` rises with the data of an accepted port B read. It is 0 after a port cycle with no port B read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock: twice the port rate in interleaved mode, the port rate in replicated mode |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0); only acts with `a_en` |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data (registered) |
| b_en | input | 1 | Port B read request |
| b_addr | input | AW | Port B address |
| b_rdata | output | DW | Port B read data (registered) |
| b_valid | output | 1 | Port B read served; low when idle or blocked |
| slot_odd | output | 1 | Interleaved mode: high during the odd (port B) slot; held low in replicated mode |

## Verification
Both modes are instantiated side by side and driven with four kinds of pattern.

A write followed by a read of the same address separates correct storage from lost writes. Concurrent port A and port B reads of different addresses expose any swap of the slot or array that serves each port. A write and read of the same address in one port cycle tells write-before-read ordering apart from read-before-write. In replicated mode, a port B read that collides with a write separates a correctly blocked read from one that returns stale or misrouted data.

A write with the enable low, together with the lowest and highest addresses, covers the boundary cases.

// File: rtl/spdp_pkg.sv
package spdp_pkg;
  typedef enum logic {
    EMU_TDM  = 1'b0,
    EMU_REPL = 1'b1
  } emu_mode_e;
endpackage

// File: rtl/spdp_spram.sv
module spdp_spram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // storage array without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  // output register updates only on a read access
  always_ff @(posedge clk) begin
    if (rst)             rdata <= '0;
    else if (en && !we)  rdata <= mem[addr];
  end
endmodule

// File: rtl/spdp_tdm_core.sv
module spdp_tdm_core #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata,
  output logic          b_valid,
  output logic          slot_odd
);
  logic          phase;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_q;
  logic          a_rd_q, b_rd_q;

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  // even slot: port A, odd slot: port B (read only)
  always_comb begin
    ram_en   = phase ? b_en   : a_en;
    ram_we   = !phase && a_we;
    ram_addr = phase ? b_addr : a_addr;
  end

  spdp_spram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst(rst), .en(ram_en), .we(ram_we),
    .addr(ram_addr), .wdata(a_wdata), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rd_q  <= 1'b0;
      b_rd_q  <= 1'b0;
      a_rdata <= '0;
      b_rdata <= '0;
      b_valid <= 1'b0;
    end else if (!phase) begin
      a_rd_q  <= a_en && !a_we;
      b_valid <= b_rd_q;
      if (b_rd_q) b_rdata <= ram_q;
    end else begin
      b_rd_q  <= b_en;
      if (a_rd_q) a_rdata <= ram_q;
    end
  end

  assign slot_odd = phase;
endmodule

// File: rtl/spdp_repl_core.sv
module spdp_repl_core #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata,
  output logic          b_valid
);
  logic          a_wr;
  logic          cp_en;
  logic [AW-1:0] cp_addr;

  assign a_wr = a_en && a_we;

  // replica: a port A write takes priority, then a port B read, else address zero
  always_comb begin
    cp_en   = a_wr || b_en;
    cp_addr = a_wr ? a_addr : (b_en ? b_addr : '0);
  end

  spdp_spram #(.AW(AW), .DW(DW)) u_main (
    .clk(clk), .rst(rst), .en(a_en), .we(a_we),
    .addr(a_addr), .wdata(a_wdata), .rdata(a_rdata)
  );

  spdp_spram #(.AW(AW), .DW(DW)) u_copy (
    .clk(clk), .rst(rst), .en(cp_en), .we(a_wr),
    .addr(cp_addr), .wdata(a_wdata), .rdata(b_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) b_valid <= 1'b0;
    else     b_valid <= b_en && !a_wr;
  end
endmodule

// File: rtl/sp_dualport_emu.sv
module sp_dualport_emu
  import spdp_pkg::*;
#(
  parameter emu_mode_e MODE = EMU_TDM,
  parameter int        AW   = 8,
  parameter int        DW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata,
  output logic          b_valid,
  output logic          slot_odd
);
  generate
    if (MODE == EMU_TDM) begin : g_tdm
      spdp_tdm_core #(.AW(AW), .DW(DW)) u_core (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_addr(b_addr), .b_rdata(b_rdata), .b_valid(b_valid),
        .slot_odd(slot_odd)
      );
    end else begin : g_repl
      spdp_repl_core #(.AW(AW), .DW(DW)) u_core (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_addr(b_addr), .b_rdata(b_rdata), .b_valid(b_valid)
      );
      assign slot_odd = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sp_dualport_emu_chk.sv
module sp_dualport_emu_chk
  import spdp_pkg::*;
#(
  parameter emu_mode_e MODE = EMU_TDM,
  parameter int        AW   = 8,
  parameter int        DW   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          a_en,
  input logic          a_we,
  input logic [DW-1:0] a_rdata,
  input logic          b_en,
  input logic [DW-1:0] b_rdata,
  input logic          b_valid,
  input logic          slot_odd
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (a_rdata == '0 && b_rdata == '0 && !b_valid && !slot_odd));

  generate
    if (MODE == EMU_TDM) begin : g_tdm
      a_r3_slot_toggles: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (slot_odd != $past(slot_odd)));
      a_r3_b_only_on_even: assert property (@(posedge clk) disable iff (rst)
        slot_odd |=> ($stable(b_rdata) && $stable(b_valid)));
      a_r5_a_only_on_odd: assert property (@(posedge clk) disable iff (rst)
        !slot_odd |=> $stable(a_rdata));
      a_r2_a_holds_without_read: assert property (@(posedge clk) disable iff (rst)
        (!slot_odd && !(a_en && !a_we)) |=> ##1 $stable(a_rdata));
      a_r10_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        (slot_odd && b_en) |=> ##1 b_valid);
    end else begin : g_repl
      a_r7_blocked_read: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we && b_en) |=> (!b_valid && $stable(b_rdata)));
      a_r8_served_read: assert property (@(posedge clk) disable iff (rst)
        (b_en && !(a_en && a_we)) |=> b_valid);
      a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> !b_valid);
      a_r1_no_slot_in_repl: assert property (@(posedge clk) disable iff (rst)
        !slot_odd);
    end
  endgenerate
endmodule

bind sp_dualport_emu sp_dualport_emu_chk #(.MODE(MODE), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_sp_dualport_emu.sv
module tb_sp_dualport_emu;
  import spdp_pkg::*;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          t_a_en = 0, t_a_we = 0, t_b_en = 0;
  logic [AW-1:0] t_a_addr = '0, t_b_addr = '0;
  logic [DW-1:0] t_a_wdata = '0, t_a_rdata, t_b_rdata;
  logic          t_b_valid, t_slot;

  logic          r_a_en = 0, r_a_we = 0, r_b_en = 0;
  logic [AW-1:0] r_a_addr = '0, r_b_addr = '0;
  logic [DW-1:0] r_a_wdata = '0, r_a_rdata, r_b_rdata;
  logic          r_b_valid, r_slot;

  sp_dualport_emu #(.MODE(EMU_TDM), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .a_en(t_a_en), .a_we(t_a_we), .a_addr(t_a_addr),
    .a_wdata(t_a_wdata), .a_rdata(t_a_rdata), .b_en(t_b_en), .b_addr(t_b_addr),
    .b_rdata(t_b_rdata), .b_valid(t_b_valid), .slot_odd(t_slot)
  );

  sp_dualport_emu #(.MODE(EMU_REPL), .AW(AW), .DW(DW)) dut_r (
    .clk(clk), .rst(rst), .a_en(r_a_en), .a_we(r_a_we), .a_addr(r_a_addr),
    .a_wdata(r_a_wdata), .a_rdata(r_a_rdata), .b_en(r_b_en), .b_addr(r_b_addr),
    .b_rdata(r_b_rdata), .b_valid(r_b_valid), .slot_odd(r_slot)
  );

  typedef enum int {K_TA, K_TB, K_TV, K_TS, K_RA, K_RB, K_RV} kind_e;
  typedef struct {
    kind_e         kind;
    logic [DW-1:0] exp;
    string         req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  logic [DW-1:0] last_rb = '0;

  task automatic push(input kind_e k, input logic [DW-1:0] e, input string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    exp_q.push_back(it);
  endtask

  // monitor: pops expected items and compares them with the sampled outputs
  task automatic drain();
    while (exp_q.size() > 0) begin
      item_t it;
      logic [DW-1:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        K_TA:    act = t_a_rdata;
        K_TB:    act = t_b_rdata;
        K_TV:    act = {{(DW-1){1'b0}}, t_b_valid};
        K_TS:    act = {{(DW-1){1'b0}}, t_slot};
        K_RA:    act = r_a_rdata;
        K_RB:    act = r_b_rdata;
        default: act = {{(DW-1){1'b0}}, r_b_valid};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%s actual=%h expected=%h", it.req, it.kind.name(), act, it.exp);
      end
    end
  endtask

  // interleaved op: starts at a negedge with slot even, ends the same way
  task automatic tdm_op(input logic aen, input logic awe, input logic [AW-1:0] aa,
                        input logic [DW-1:0] ad, input logic ben, input logic [AW-1:0] ba,
                        input bit chk_a, input logic [DW-1:0] ea, input string ra,
                        input bit chk_b, input logic [DW-1:0] eb, input string rb);
    push(K_TS, 0, "R3"); drain();
    t_a_en = aen; t_a_we = awe; t_a_addr = aa; t_a_wdata = ad;
    t_b_en = ben; t_b_addr = ba;
    @(posedge clk); @(negedge clk);
    push(K_TS, 1, "R3"); drain();
    @(posedge clk); @(negedge clk);
    if (chk_a) begin push(K_TA, ea, ra); drain(); end
    t_a_en = 0; t_a_we = 0; t_b_en = 0;
    @(posedge clk); @(negedge clk);
    push(K_TV, {{(DW-1){1'b0}}, ben}, "R10");
    if (chk_b) push(K_TB, eb, rb);
    drain();
    @(posedge clk); @(negedge clk);
    if (chk_b) begin push(K_TB, eb, "R5"); drain(); end
  endtask

  task automatic repl_op(input logic aen, input logic awe, input logic [AW-1:0] aa,
                         input logic [DW-1:0] ad, input logic ben, input logic [AW-1:0] ba,
                         input bit chk_a, input logic [DW-1:0] ea, input string ra,
                         input bit chk_b, input logic [DW-1:0] eb, input string rb,
                         input logic ev, input string rv);
    r_a_en = aen; r_a_we = awe; r_a_addr = aa; r_a_wdata = ad;
    r_b_en = ben; r_b_addr = ba;
    @(posedge clk); @(negedge clk);
    if (chk_a) push(K_RA, ea, ra);
    if (chk_b) push(K_RB, eb, rb);
    push(K_RV, {{(DW-1){1'b0}}, ev}, rv);
    drain();
    r_a_en = 0; r_a_we = 0; r_b_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values on both instances
    push(K_TA, 0, "R1"); push(K_TB, 0, "R1"); push(K_TV, 0, "R1"); push(K_TS, 0, "R1");
    push(K_RA, 0, "R1"); push(K_RB, 0, "R1"); push(K_RV, 0, "R1");
    drain();
    rst = 0;

    // ---- interleaved mode ----
    tdm_op(1, 1, 8'h10, 16'h1234, 0, 8'h00, 0, 0, "R2", 0, 0, "R4");
    tdm_op(1, 1, 8'h00, 16'h0F0F, 0, 8'h00, 0, 0, "R2", 0, 0, "R4");
    tdm_op(1, 1, 8'hFF, 16'h0001, 0, 8'h00, 0, 0, "R2", 0, 0, "R4");
    // R4: write and same-address read in one port cycle
    tdm_op(1, 1, 8'h20, 16'hBEEF, 1, 8'h20, 0, 0, "R2", 1, 16'hBEEF, "R4");
    // R2 and R3: concurrent reads of different addresses
    tdm_op(1, 0, 8'h10, 16'h0000, 1, 8'h20, 1, 16'h1234, "R2", 1, 16'hBEEF, "R3");
    tdm_op(1, 0, 8'h20, 16'h0000, 1, 8'h10, 1, 16'hBEEF, "R3", 1, 16'h1234, "R3");
    // R9: a_we without a_en writes nothing; boundary addresses
    tdm_op(0, 1, 8'hFF, 16'hA5A5, 0, 8'h00, 0, 0, "R9", 0, 0, "R9");
    tdm_op(1, 0, 8'hFF, 16'h0000, 1, 8'h00, 1, 16'h0001, "R9", 1, 16'h0F0F, "R2");

    // ---- replicated mode ----
    repl_op(1, 1, 8'h33, 16'h5555, 0, 8'h00, 0, 0, "R2", 0, 0, "R6", 0, "R8");
    repl_op(1, 1, 8'h44, 16'h7777, 0, 8'h00, 0, 0, "R2", 0, 0, "R6", 0, "R8");
    // R6 and R8: port B sees port A writes; both ports read at once
    repl_op(1, 0, 8'h44, 16'h0000, 1, 8'h33, 1, 16'h7777, "R2", 1, 16'h5555, "R6", 1, "R8");
    last_rb = 16'h5555;
    // R7: collision blocks port B and holds its data
    repl_op(1, 1, 8'h33, 16'h9999, 1, 8'h44, 0, 0, "R2", 1, last_rb, "R7", 0, "R7");
    repl_op(0, 0, 8'h00, 16'h0000, 1, 8'h33, 0, 0, "R2", 1, 16'h9999, "R6", 1, "R8");
    // R9: disabled write leaves the word intact
    repl_op(0, 1, 8'h44, 16'h0000, 1, 8'h44, 0, 0, "R9", 1, 16'h7777, "R9", 1, "R8");
    repl_op(1, 0, 8'h44, 16'h0000, 0, 8'h00, 1, 16'h7777, "R9", 0, 0, "R8", 0, "R8");
    repl_op(1, 1, 8'hFF, 16'hC3C3, 0, 8'h00, 0, 0, "R2", 0, 0, "R6", 0, "R8");
    repl_op(1, 0, 8'hFF, 16'h0000, 1, 8'hFF, 1, 16'hC3C3, "R2", 1, 16'hC3C3, "R6", 1, "R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule